// File: doc/BRIEF.md
# Pipelined Byte-Lane SRAM with Write Pass-Through

This block is a single-port synchronous memory. Every access is captured at a clock edge: address, chip select, write data and all write controls. Reads come back through an output register. Writes go first into a one-entry posted-write buffer and are committed to the array on the following edge.

Each word is divided into byte lanes of nine bits: eight data bits and one parity bit. A write may touch any subset of lanes. A lane is selected by its own lane enable, which counts only while the byte-write enable is low. Alternatively, the global write input selects every lane at once. A forwarding merge returns the newest data to a read that immediately follows a write to the same address, including partially written words.

An output enable gates the pad drive-enable and the data asynchronously. The burst address sequence is supplied by a separate block. After the two-register latency, back-to-back reads return one word per clock.

The captured command register is a three-state machine. Its states are CMD_IDLE (deselected), CMD_READ and CMD_WRITE. Every edge it moves from any state to the state that the current cycle's inputs decode:
- CMD_IDLE when chip select is high.
- CMD_WRITE when any lane is selected for writing.
- CMD_READ otherwise.

Reset forces CMD_IDLE.

Top module: `bwsram_pipe`

## Requirements
- R1: Lane k occupies word bits [9k+8:9k], and bit 9k+8 is its parity bit. A partial write replaces all nine bits of each selected lane and leaves every other lane unchanged.
- R2: Lane enables (active low) select a lane only while bwe_n is low. With gw_n and bwe_n both high, the cycle is a read, whatever the lane enables are.
- R3: With gw_n low, every lane is written, whatever bwe_n and the lane enables are.
- R4: A read presented before rising edge N drives its word on dq_o with dq_oe high after edge N+1. Consecutive reads deliver one word per clock.
- R5: A read of an address in the cycle right after a write to it returns the merged new contents.
- R6: A cycle with cs_n high writes nothing and leaves dq_oe low in its output slot.
- R7: oe_n high forces dq_oe low and dq_o to zero without waiting for a clock edge. Returning oe_n low restores the registered word at once.
- R8: The output slot of a write cycle has dq_oe low.
- R9: After reset, dq_oe is low and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control pipeline |
| cs_n | input | 1 | Active-low chip select, captured with the address |
| addr | input | ADDR_W | Word address |
| wdata | input | 9*LANES | Write word, nine bits per lane |
| lane_we_n | input | LANES | Active-low per-lane write enables |
| bwe_n | input | 1 | Active-low qualifier for the lane enables |
| gw_n | input | 1 | Active-low write of all lanes |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_o | output | 9*LANES | Read word, zero when not driven |
| dq_oe | output | 1 | Pad drive enable |

## Verification
The commit of a posted write and the array read of the following access happen on the same edge. When both use one address, the read must take the buffered lanes rather than the stale array word. The bench provokes this with directed write-then-read pairs, both full-word and single-lane, and with random traffic over a narrow address range so that back-to-back collisions are frequent. Each returned word is judged against a sequential memory model that applies every write the moment it is issued.

// File: rtl/bwsram_pkg.sv
package bwsram_pkg;
    localparam int LANE_BITS = 9;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;
endpackage

// File: rtl/bwsram_wdec.sv
module bwsram_wdec
    import bwsram_pkg::*;
#(
    parameter int LANES = 2,
    localparam int DW = LANES * LANE_BITS
) (
    input  logic             cs_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_we_n,
    output cmd_e             cmd,
    output logic [DW-1:0]    bit_mask
);
    logic [LANES-1:0] lane_on;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_on[k] = ~gw_n | (~bwe_n & ~lane_we_n[k]);
        assign bit_mask[k*LANE_BITS +: LANE_BITS] = {LANE_BITS{lane_on[k]}};
    end

    always_comb begin
        if (cs_n)          cmd = CMD_IDLE;
        else if (|lane_on) cmd = CMD_WRITE;
        else               cmd = CMD_READ;
    end
endmodule

// File: rtl/bwsram_array.sv
module bwsram_array #(
    parameter int ADDR_W = 6,
    parameter int DW = 18,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     wmask,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DW-1:0]     rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/bwsram_fwd.sv
module bwsram_fwd #(
    parameter int ADDR_W = 6,
    parameter int DW = 18
) (
    input  logic [DW-1:0]     arr_data,
    input  logic              wb_valid,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DW-1:0]     wb_data,
    input  logic [DW-1:0]     wb_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     merged
);
    logic hit;

    assign hit    = wb_valid && (wb_addr == rd_addr);
    assign merged = hit ? ((arr_data & ~wb_mask) | (wb_data & wb_mask)) : arr_data;
endmodule

// File: rtl/bwsram_pipe.sv
module bwsram_pipe
    import bwsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES = 2,
    localparam int DW = LANES * LANE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              bwe_n,
    input  logic              gw_n,
    input  logic              oe_n,
    output logic [DW-1:0]     dq_o,
    output logic              dq_oe
);
    cmd_e              dec_cmd;
    logic [DW-1:0]     dec_mask;
    cmd_e              s1_state;
    logic [ADDR_W-1:0] s1_addr;
    logic [DW-1:0]     s1_data;
    logic [DW-1:0]     s1_mask;
    logic              wb_valid;
    logic [ADDR_W-1:0] wb_addr;
    logic [DW-1:0]     wb_data;
    logic [DW-1:0]     wb_mask;
    logic [DW-1:0]     arr_rdata;
    logic [DW-1:0]     fwd_rdata;
    logic              out_valid;
    logic [DW-1:0]     dq_q;

    bwsram_wdec #(.LANES(LANES)) u_wdec (
        .cs_n      (cs_n),
        .gw_n      (gw_n),
        .bwe_n     (bwe_n),
        .lane_we_n (lane_we_n),
        .cmd       (dec_cmd),
        .bit_mask  (dec_mask)
    );

    // Command state register: next state is the decoded current cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s1_state <= CMD_IDLE;
        else        s1_state <= dec_cmd;
    end

    always_ff @(posedge clk) begin
        s1_addr <= addr;
        s1_data <= wdata;
        s1_mask <= dec_mask;
    end

    // Posted write buffer: committed to the array on the following edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wb_valid <= 1'b0;
        else        wb_valid <= (s1_state == CMD_WRITE);
    end

    always_ff @(posedge clk) begin
        if (s1_state == CMD_WRITE) begin
            wb_addr <= s1_addr;
            wb_data <= s1_data;
            wb_mask <= s1_mask;
        end
    end

    bwsram_array #(.ADDR_W(ADDR_W), .DW(DW)) u_array (
        .clk   (clk),
        .we    (wb_valid),
        .waddr (wb_addr),
        .wdata (wb_data),
        .wmask (wb_mask),
        .raddr (s1_addr),
        .rdata (arr_rdata)
    );

    bwsram_fwd #(.ADDR_W(ADDR_W), .DW(DW)) u_fwd (
        .arr_data (arr_rdata),
        .wb_valid (wb_valid),
        .wb_addr  (wb_addr),
        .wb_data  (wb_data),
        .wb_mask  (wb_mask),
        .rd_addr  (s1_addr),
        .merged   (fwd_rdata)
    );

    // Output register stage, steered by the command state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dq_q      <= '0;
        end else begin
            unique case (s1_state)
                CMD_READ: begin
                    out_valid <= 1'b1;
                    dq_q      <= fwd_rdata;
                end
                CMD_WRITE, CMD_IDLE: out_valid <= 1'b0;
                default:             out_valid <= 1'b0;
            endcase
        end
    end

    // Asynchronous output gating.
    always_comb begin
        dq_oe = out_valid & ~oe_n;
        dq_o  = dq_oe ? dq_q : '0;
    end
endmodule

// File: rtl/bwsram_pipe_chk.sv
module bwsram_pipe_chk
    import bwsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES = 2,
    localparam int DW = LANES * LANE_BITS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              gw_n,
    input logic              bwe_n,
    input logic              oe_n,
    input logic              dq_oe,
    input cmd_e              s1_state,
    input logic [ADDR_W-1:0] s1_addr,
    input logic [DW-1:0]     s1_mask,
    input logic              wb_valid,
    input logic [ADDR_W-1:0] wb_addr,
    input logic              out_valid
);
    p_gw_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !gw_n) |=> (s1_state == CMD_WRITE && &s1_mask));

    p_bwe_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && gw_n && bwe_n) |=> (s1_state == CMD_READ));

    p_desel_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_state == CMD_IDLE) |=> !out_valid);

    p_write_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_state == CMD_WRITE) |=> (!out_valid && wb_valid && wb_addr == $past(s1_addr)));

    p_read_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_state == CMD_READ) |=> out_valid);

    p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);
endmodule

bind bwsram_pipe bwsram_pipe_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .gw_n      (gw_n),
    .bwe_n     (bwe_n),
    .oe_n      (oe_n),
    .dq_oe     (dq_oe),
    .s1_state  (s1_state),
    .s1_addr   (s1_addr),
    .s1_mask   (s1_mask),
    .wb_valid  (wb_valid),
    .wb_addr   (wb_addr),
    .out_valid (out_valid)
);

// File: tb/bwsram_pipe_bench.sv
`timescale 1ns/1ps
module bwsram_pipe_bench;
    localparam int AW = 6;
    localparam int L  = 2;
    localparam int DW = 9 * L;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [L-1:0]  lane_we_n = '1;
    logic          bwe_n = 1'b1;
    logic          gw_n = 1'b1;
    logic          oe_n = 1'b0;
    logic [DW-1:0] dq_o;
    logic          dq_oe;

    int n_chk = 0;
    int n_fail = 0;

    logic [DW-1:0] mem_m [DEPTH];
    logic          p_v [2];
    logic [DW-1:0] p_d [2];
    string         p_t [2];

    always #2.5 clk = ~clk;

    bwsram_pipe #(.ADDR_W(AW), .LANES(L)) u_bwsram_pipe (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .wdata(wdata),
        .lane_we_n(lane_we_n), .bwe_n(bwe_n), .gw_n(gw_n), .oe_n(oe_n),
        .dq_o(dq_o), .dq_oe(dq_oe)
    );

    function automatic logic [DW-1:0] mask_of(input logic gw, input logic bwe, input logic [L-1:0] lwe);
        logic [DW-1:0] m = '0;
        for (int k = 0; k < L; k++)
            if (!gw || (!bwe && !lwe[k])) m[k*9 +: 9] = 9'h1FF;
        return m;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_slot();
        if (p_v[1]) check(dq_oe && dq_o == p_d[1], p_t[1], dq_o, p_d[1]);
        else        check(!dq_oe && dq_o == '0, p_t[1], {{(DW-1){1'b0}}, dq_oe}, '0);
    endtask

    // One access: check the slot due now, then present a new access.
    task automatic step(input logic cs, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [L-1:0] lwe, input logic bwe, input logic gw, input string tag);
        logic [DW-1:0] m;
        @(negedge clk);
        check_slot();
        p_v[1] = p_v[0]; p_d[1] = p_d[0]; p_t[1] = p_t[0];
        cs_n = cs; addr = a; wdata = d; lane_we_n = lwe; bwe_n = bwe; gw_n = gw;
        m = mask_of(gw, bwe, lwe);
        if (!cs && |m) mem_m[a] = (mem_m[a] & ~m) | (d & m);
        p_v[0] = !cs && !(|m);
        p_d[0] = mem_m[a];
        p_t[0] = tag;
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        step(1'b0, a, '0, '1, 1'b1, 1'b1, tag);
    endtask

    task automatic idle();
        step(1'b1, '0, '0, '1, 1'b1, 1'b1, "R6");
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [DW-1:0] ex;
        logic [AW-1:0] last_wa;
        logic          last_w;
        p_v[0] = 1'b0; p_v[1] = 1'b0; p_d[0] = '0; p_d[1] = '0;
        p_t[0] = "R9"; p_t[1] = "R9";
        repeat (3) @(posedge clk);
        #1 check(!dq_oe, "R9 reset drive", {{(DW-1){1'b0}}, dq_oe}, '0);
        rst_n = 1'b1;

        // Fill every word with a full global write.
        for (int i = 0; i < DEPTH; i++)
            step(1'b0, AW'(i), DW'(i * 1031 + 7), '1, 1'b1, 1'b0, "R8");
        for (int i = 0; i < 4; i++) rd(AW'(i * 9), "R4");

        // R1: single-lane write leaves the other lane, parity bit included.
        step(1'b0, 6'd5, 18'h3FFFF, '1, 1'b1, 1'b0, "R8");
        step(1'b0, 6'd5, 18'h00000, 2'b10, 1'b0, 1'b1, "R1 lane0 write");
        idle();
        rd(6'd5, "R1 lane0 cleared lane1 kept");
        step(1'b0, 6'd5, 18'h3FE00, 2'b01, 1'b0, 1'b1, "R1 lane1 write");
        idle();
        rd(6'd5, "R1 parity bit 17");

        // R2: lane enables ignored while bwe_n high: a read, no change.
        step(1'b0, 6'd12, 18'h15555, 2'b00, 1'b1, 1'b1, "R2 treated as read");
        idle();
        rd(6'd12, "R2 word unchanged");

        // R3: global write overrides lane enables and bwe_n.
        step(1'b0, 6'd20, 18'h2AAAA, 2'b11, 1'b1, 1'b0, "R8");
        idle();
        rd(6'd20, "R3 all lanes written");

        // R5: write then read same address back-to-back.
        step(1'b0, 6'd30, 18'h1C3A5, '1, 1'b1, 1'b0, "R8");
        rd(6'd30, "R5 full pass-through");
        step(1'b0, 6'd30, 18'h3FFFF, 2'b01, 1'b0, 1'b1, "R8");
        rd(6'd30, "R5 partial merge");
        step(1'b0, 6'd31, 18'h0F0F0, 2'b10, 1'b0, 1'b1, "R8");
        rd(6'd31, "R5 lane0 merge");
        rd(6'd31, "R4 back-to-back");

        // R6: deselected write attempt changes nothing.
        step(1'b1, 6'd40, 18'h12345, 2'b00, 1'b0, 1'b0, "R6 deselected");
        idle();
        rd(6'd40, "R6 word unchanged");

        // R7: asynchronous output enable.
        rd(6'd20, "R7 slot");
        ex = mem_m[20];
        idle();
        @(posedge clk); #1;
        oe_n = 1'b1; #0.5;
        check(!dq_oe && dq_o == '0, "R7 oe_n high", dq_o, '0);
        oe_n = 1'b0; #0.5;
        check(dq_oe && dq_o == ex, "R7 oe_n low", dq_o, ex);

        // Random traffic over a narrow address range.
        void'($urandom(32'd1357));
        last_w = 1'b0; last_wa = '0;
        for (int i = 0; i < 600; i++) begin
            int kind = $urandom_range(0, 9);
            logic [AW-1:0] a = AW'($urandom_range(0, 3));
            logic [DW-1:0] d = DW'($urandom);
            logic [L-1:0] lwe = L'($urandom);
            if (kind == 0) begin
                step(1'b1, a, d, lwe, 1'($urandom), 1'($urandom), "R6");
                last_w = 1'b0;
            end else if (kind < 5) begin
                if (kind == 1) step(1'b0, a, d, lwe, 1'b1, 1'b0, "R8");
                else           step(1'b0, a, d, lwe | 2'b01 << $urandom_range(0,1) ^ 2'b11, 1'b0, 1'b1, "R8");
                last_w = 1'b1; last_wa = a;
            end else begin
                if (last_w && last_wa == a) rd(a, "R5 random");
                else step(1'b0, a, '0, lwe, 1'b1, 1'b1, "R4 random");
                last_w = 1'b0;
            end
        end
        idle(); idle(); idle();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule